// File: doc/BRIEF.md
# Windowed Watchdog with Early Warning

This block is a windowed watchdog. It has a 7-bit down-counter that software loads and arms by writing a control register. Once armed, the counter steps down by one on each prescaled tick. Software has to reload it while its value sits between a programmable window value and 0x40. Three events raise a one-cycle system reset request:
- the counter falls from 0x40 to 0x3F;
- software reloads it while the value is still above the window;
- software arms it with a value whose bit 6 is already clear.

An optional early-warning flag is set when the counter reaches 0x40. This gives an interrupt handler one last tick period to reload the counter.

Access is through a small register slave with a halfword strobe pair, so both 16-bit and 32-bit accesses work. A debug-halt input, qualified by a freeze-enable input, stops counting while a processor is halted.

Top module: `winwdog`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x7F, the configuration register (offset 0x4) reads 0x7F, the status register (offset 0x8) reads 0, and both `irq` and `rst_req` are low.
- R2: Bit 7 of the control register is the arm bit. Writing 1 sets it. Writing 0 leaves it unchanged. Only the block's reset clears it.
- R3: Bits 6:0 of the control register are the counter. A write loads them at once, and a read returns them. Bits 31:8 of the control register, bits 31:10 of the configuration register and bits 31:1 of the status register read 0.
- R4: While the arm bit is set, the counter decrements by one every BASE_DIV·2^S clock cycles. S is the prescale select in configuration bits 8:7. The prescale count restarts from zero while the block is unarmed. A counter write in the same cycle as a tick takes priority over the decrement.
- R5: When the counter steps from 0x40 to 0x3F, `rst_req` is high for exactly the following cycle.
- R6: A control write while armed, with the counter greater than the window W (configuration bits 6:0), raises `rst_req` the following cycle.
- R7: A control write with bit 7 = 1 and bit 6 = 0 raises `rst_req` the following cycle.
- R8: With the early-warning enable (configuration bit 9) set, a tick that takes the counter from 0x41 to 0x40 sets status bit 0. `irq` follows that bit.
- R9: Writing 0 to status bit 0 clears it, and writing 1 has no effect. A flag-setting tick in the same cycle as a clearing write wins.
- R10: While `dbg_halt` and `dbg_freeze_en` are both high, the counter and the prescale count hold their values.
- R11: `bus_strb[0]` enables a write of bits 15:0 and `bus_strb[1]` a write of bits 31:16. A write with only `bus_strb[1]` changes nothing. Read data appears on `bus_rdata` one cycle after the request and holds until the next read. Unmapped offsets read 0.
- R12: A reload of the counter, inside the window, between the early warning and the 0x40 to 0x3F step prevents the reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_strb | input | 2 | Halfword write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Processor halted |
| dbg_freeze_en | input | 1 | Allow halt to freeze counting |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Register writes take effect at the rising edge that samples them, and `rst_req` and `irq` change at that same edge. Read data follows one edge after the request. A tick-driven event shows on the outputs at the edge where the prescale count reaches its limit. The bench keeps a reference model of the registers and the prescaler that advances on the same rising edges as the design. It compares `rst_req`, `irq` and `bus_rdata` with that model on every falling edge. This means each result is checked in the exact cycle it is due. The directed cases also sample one falling edge after the edge that captured their stimulus.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;
  localparam int CW = 7;
  localparam logic [CW-1:0] CNT_RST  = 7'h7F;
  localparam logic [CW-1:0] WARN_VAL = 7'h40;
  localparam int ARM_BIT  = 7;
  localparam int SIGN_BIT = 6;
  localparam int IDX_CTRL = 0;
  localparam int IDX_CFG  = 1;
  localparam int IDX_STAT = 2;

  typedef struct packed {
    logic          warn_en;
    logic [1:0]    psel;
    logic [CW-1:0] win;
  } wcfg_t;
endpackage

// File: rtl/winwdog_tick.sv
module winwdog_tick #(
  parameter int BASE_DIV = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       hold,
  input  logic [1:0] psel,
  output logic       tick
);
  localparam int PW = $clog2(BASE_DIV * 8) + 1;

  logic [PW-1:0] pc_q;
  logic [PW-1:0] limit;

  assign limit = (PW'(BASE_DIV) << psel) - PW'(1);
  assign tick  = run && !hold && (pc_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc_q <= '0;
    end else if (!hold) begin
      pc_q <= tick ? '0 : pc_q + PW'(1);
    end
  end
endmodule

// File: rtl/winwdog_regs.sv
module winwdog_regs
  import winwdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_strb,
  input  logic [31:0]       bus_wdata,
  input  logic [CW-1:0]     cnt,
  input  logic              armed,
  input  logic              flag,
  output logic [31:0]       bus_rdata,
  output logic              ctrl_we,
  output logic              stat_we,
  output wcfg_t             cfg
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] idx;
  logic          lo_we;
  logic [31:0]   rd_mux;
  logic          cfg_we;
  logic          unused_bits;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign lo_we   = bus_sel && bus_wr && bus_strb[0];
  assign ctrl_we = lo_we && (idx == IW'(IDX_CTRL));
  assign cfg_we  = lo_we && (idx == IW'(IDX_CFG));
  assign stat_we = lo_we && (idx == IW'(IDX_STAT));
  assign unused_bits = ^{bus_addr[1:0], bus_strb[1], bus_wdata[31:10]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{warn_en: 1'b0, psel: 2'd0, win: CNT_RST};
    end else if (cfg_we) begin
      cfg <= bus_wdata[9:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (idx == IW'(IDX_CTRL))      rd_mux = {24'd0, armed, cnt};
    else if (idx == IW'(IDX_CFG))  rd_mux = {22'd0, cfg};
    else if (idx == IW'(IDX_STAT)) rd_mux = {31'd0, flag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/winwdog_core.sv
module winwdog_core
  import winwdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_we,
  input  logic          stat_we,
  input  logic [7:0]    wbyte,
  input  wcfg_t         cfg,
  output logic [CW-1:0] cnt_q,
  output logic          arm_q,
  output logic          flag_q,
  output logic          rst_req_q
);
  logic step;
  logic early;
  logic bad_arm;
  logic expire;
  logic warn;

  assign step    = tick && !ctrl_we;
  assign early   = ctrl_we && arm_q && (cnt_q > cfg.win);
  assign bad_arm = ctrl_we && wbyte[ARM_BIT] && !wbyte[SIGN_BIT];
  assign expire  = step && (cnt_q == WARN_VAL);
  assign warn    = step && cfg.warn_en && (cnt_q == WARN_VAL + CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= CNT_RST;
      arm_q     <= 1'b0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= early || bad_arm || expire;
      if (ctrl_we) begin
        cnt_q <= wbyte[CW-1:0];
        if (wbyte[ARM_BIT]) arm_q <= 1'b1;
      end else if (step) begin
        cnt_q <= cnt_q - CW'(1);
      end
      if (warn)                      flag_q <= 1'b1;
      else if (stat_we && !wbyte[0]) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/winwdog.sv
module winwdog
  import winwdog_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_strb,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt,
  input  logic              dbg_freeze_en,
  output logic              irq,
  output logic              rst_req
);
  logic [CW-1:0] cnt_q;
  logic          arm_q;
  logic          flag_q;
  logic          tick;
  logic          frozen;
  logic          ctrl_we;
  logic          stat_we;
  wcfg_t         cfg_q;

  assign frozen = dbg_halt && dbg_freeze_en;

  winwdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .cnt(cnt_q), .armed(arm_q), .flag(flag_q), .bus_rdata(bus_rdata),
    .ctrl_we(ctrl_we), .stat_we(stat_we), .cfg(cfg_q)
  );

  winwdog_tick #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(arm_q), .hold(frozen),
    .psel(cfg_q.psel), .tick(tick)
  );

  winwdog_core u_core (
    .clk(clk), .rst(rst), .tick(tick), .ctrl_we(ctrl_we), .stat_we(stat_we),
    .wbyte(bus_wdata[7:0]), .cfg(cfg_q), .cnt_q(cnt_q), .arm_q(arm_q),
    .flag_q(flag_q), .rst_req_q(rst_req)
  );

  assign irq = flag_q;
endmodule

// File: rtl/winwdog_checker.sv
module winwdog_checker (
  input logic        clk,
  input logic        rst,
  input logic [6:0]  cnt,
  input logic        armed,
  input logic        tick,
  input logic        ctrl_we,
  input logic        frozen,
  input logic        warn_en,
  input logic [31:0] wdata,
  input logic        irq,
  input logic        rst_req
);
  assert_arm_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (cnt == $past(wdata[6:0])));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctrl_we) |=> $stable(cnt));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctrl_we) |=> (cnt == $past(cnt) - 7'd1));

  assert_expire_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctrl_we && cnt == 7'h40) |=> rst_req);

  assert_warn_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctrl_we && warn_en && cnt == 7'h41) |=> irq);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    frozen |-> !tick);
endmodule

bind winwdog winwdog_checker u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .armed(arm_q), .tick(tick),
  .ctrl_we(ctrl_we), .frozen(frozen), .warn_en(cfg_q.warn_en),
  .wdata(bus_wdata), .irq(irq), .rst_req(rst_req)
);

// File: tb/winwdog_test.sv
`timescale 1ns/1ps
module winwdog_test;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_strb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0, dbg_freeze_en = 1'b0;
  logic        irq, rst_req;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #4 clk = ~clk;

  winwdog #(.ADDR_W(4), .BASE_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze_en),
    .irq(irq), .rst_req(rst_req)
  );

  // reference model, stepped on the same rising edges
  logic [6:0]  m_cnt, m_win;
  logic        m_act, m_flag, m_wen, m_rst;
  logic [1:0]  m_psel;
  int          m_pc;
  logic [31:0] m_rd;

  task automatic model_step();
    int lim;
    bit frz, tk, we, cw, fw, sw, setf;
    lim  = (DIV << m_psel) - 1;
    frz  = dbg_halt && dbg_freeze_en;
    tk   = m_act && !frz && (m_pc >= lim);
    we   = bus_sel && bus_wr && bus_strb[0];
    cw   = we && bus_addr[3:2] == 2'd0;
    fw   = we && bus_addr[3:2] == 2'd1;
    sw   = we && bus_addr[3:2] == 2'd2;
    setf = 0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr[3:2])
        2'd0: m_rd = {24'd0, m_act, m_cnt};
        2'd1: m_rd = {22'd0, m_wen, m_psel, m_win};
        2'd2: m_rd = {31'd0, m_flag};
        default: m_rd = 32'd0;
      endcase
    end
    m_rst = 1'b0;
    if (!m_act) m_pc = 0;
    else if (!frz) m_pc = tk ? 0 : m_pc + 1;
    if (cw) begin
      if (m_act && m_cnt > m_win) m_rst = 1'b1;
      if (bus_wdata[7] && !bus_wdata[6]) m_rst = 1'b1;
      m_cnt = bus_wdata[6:0];
      if (bus_wdata[7]) m_act = 1'b1;
    end else if (tk) begin
      if (m_cnt == 7'h40) m_rst = 1'b1;
      if (m_cnt == 7'h41 && m_wen) setf = 1;
      m_cnt = m_cnt - 7'd1;
    end
    if (setf) m_flag = 1'b1;
    else if (sw && !bus_wdata[0]) m_flag = 1'b0;
    if (fw) begin
      m_win = bus_wdata[6:0]; m_psel = bus_wdata[8:7]; m_wen = bus_wdata[9];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 7'h7F; m_win = 7'h7F; m_act = 0; m_flag = 0; m_wen = 0;
      m_psel = 0; m_pc = 0; m_rst = 0; m_rd = 0;
    end else begin
      model_step();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(rst_req === m_rst, "R5 R6 R7 R12 rst_req", 32'(rst_req), 32'(m_rst));
      chk(irq === m_flag, "R8 R9 irq", 32'(irq), 32'(m_flag));
      chk(bus_rdata === m_rd, "R3 R4 R11 rdata", bus_rdata, m_rd);
    end
  end

  // tasks start right after a falling edge and end on one
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] s);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_strb = s;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_strb = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    bit seen;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    cmp_on = 1;

    // R1 reset values
    rd(4'h0, d); chk(d == 32'h7F, "R1 ctrl", d, 32'h7F);
    rd(4'h4, d); chk(d == 32'h7F, "R1 cfg", d, 32'h7F);
    rd(4'h8, d); chk(d == 32'h0, "R1 status", d, 32'h0);
    chk(!irq && !rst_req, "R1 outputs", {irq, rst_req}, 0);

    // R11 upper-halfword-only write is ignored; unmapped reads zero
    wr(4'h0, 32'h0000_00FF, 2'b10);
    rd(4'h0, d); chk(d == 32'h7F, "R11 upper-half write", d, 32'h7F);
    rd(4'hC, d); chk(d == 32'h0, "R11 unmapped", d, 0);

    // configure: warning on, prescale x8, window 0x7F; then arm
    wr(4'h4, 32'h0000_027F | (32'd3 << 7), 2'b11);
    wr(4'h0, 32'h0000_00FF, 2'b01);
    rd(4'h0, d); chk(d[7] == 1'b1 && d[31:8] == 0, "R2 R3 armed", d, 32'h80);
    // R4: count moves after a few tick periods
    repeat (40) @(negedge clk);
    rd(4'h0, d); chk(d[6:0] < 7'h7F, "R4 counting", d, 32'hFE);

    // R8 wait for early warning, then reload inside window (R12)
    seen = 0;
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, "R8 warning raised", 32'(irq), 1);
    wr(4'h0, 32'h0000_007F, 2'b11);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    chk(!seen, "R12 reload avoided reset", 32'(seen), 0);
    rd(4'h0, d); chk(d[7] == 1'b1, "R2 zero write keeps arm", d, 32'h80);
    rd(4'h8, d); chk(d == 32'h1, "R8 status set", d, 1);
    wr(4'h8, 32'h1, 2'b01);
    rd(4'h8, d); chk(d == 32'h1, "R9 write one no effect", d, 1);
    wr(4'h8, 32'h0, 2'b01);
    rd(4'h8, d); chk(d == 32'h0, "R9 write zero clears", d, 0);

    // R6 early refresh: window 0x50, counter near 0x7F
    wr(4'h4, 32'h0000_0250 | (32'd3 << 7), 2'b11);
    wr(4'h0, 32'h0000_007F, 2'b01);
    chk(rst_req == 1'b1, "R6 early refresh", 32'(rst_req), 1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R6 pulse width", 32'(rst_req), 0);

    // R10 freeze
    dbg_halt = 1; dbg_freeze_en = 1;
    rd(4'h0, d);
    repeat (100) @(negedge clk);
    rd(4'h0, d2); chk(d == d2, "R10 frozen", d2, d);
    dbg_freeze_en = 0;
    repeat (40) @(negedge clk);
    rd(4'h0, d2); chk(d2 != d, "R10 halt alone does not freeze", d2, d);
    dbg_halt = 0;

    // R5 timeout without reload
    for (int i = 0; i < 3000 && !rst_req; i++) @(negedge clk);
    chk(rst_req == 1'b1, "R5 timeout request", 32'(rst_req), 1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R5 one cycle", 32'(rst_req), 0);

    // R7 arming with bit 6 clear
    do_reset();
    wr(4'h0, 32'h0000_00BF, 2'b11);
    chk(rst_req == 1'b1, "R7 bad arm value", 32'(rst_req), 1);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 299);
      if (r == 0) begin
        rst = 1; @(negedge clk); rst = 0;
      end else if (r < 40) begin
        logic [31:0] v;
        logic [3:0] a;
        a = 4'($urandom_range(0, 3) << 2);
        v = $urandom;
        if (a == 4'h0 && $urandom_range(0, 3) != 0) v[6] = 1'b1;
        if ($urandom_range(0, 1) == 0) wr(a, v, 2'($urandom_range(1, 3)));
        else rd(a, v);
      end else begin
        if (r > 295) dbg_halt = ~dbg_halt;
        if (r == 295) dbg_freeze_en = ~dbg_freeze_en;
        @(negedge clk);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule